// File: doc/BRIEF.md
# Run-Length Bit Stream Expander

This block turns a stream of run-length codes into a serial bit stream for a configuration shift chain. After reset it sends a fixed 16-bit preamble. It then takes one byte at a time on a valid/ready input and expands each byte into a run of identical bits. Depending on the code, a single bit of the opposite value may close the run. The output moves one bit per cycle, and the sink can stall it with valid/ready backpressure.

Each code falls into one of four ranges, set by a maximum-run parameter (default 226). Low codes give a run of ones closed by a zero. The code just above the maximum gives a full run of ones with no closing zero. The codes above that give a run of zeros closed by a one. The all-ones code gives a lone one. Code zero gives no bits. A last-byte flag on the input comes out on the final bit of that byte's expansion.

Top module: `rle_bit_expander`

## Requirements
- R1: After reset the output first carries the 16 bits 1111_1111_0010_0000, leftmost first, one per accepted output transfer. in_ready stays low until all 16 have been taken.
- R2: A code b with 1 <= b <= RUN_MAX (226) expands to b ones followed by one zero.
- R3: Code RUN_MAX+1 (227) expands to exactly RUN_MAX ones with no closing zero.
- R4: A code b with RUN_MAX+2 <= b <= 254 expands to b-(RUN_MAX+2) zeros followed by one one. Code 228 is therefore a single one.
- R5: Code 255 expands to a single one.
- R6: Code 0 produces no output bit. in_ready is high again in the cycle after it is accepted, and its in_last flag is discarded.
- R7: in_ready is high only when no preamble or expansion bit is pending. After a nonzero byte is accepted, out_valid is high and in_ready is low in the next cycle.
- R8: While out_valid is high and out_ready is low, out_valid, out_bit and out_last hold their values into the next cycle.
- R9: out_last is high only on the final bit of the expansion of a byte accepted with in_last high, and low on every other bit, including all preamble bits.
- R10: Synchronous active-high reset aborts any expansion and restarts the preamble. In the first cycle after reset, out_valid is 1, out_bit is 1 and in_ready is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input code is offered |
| in_code | input | 8 | Run-length code byte |
| in_last | input | 1 | Marks the final byte of a stream |
| in_ready | output | 1 | Block can take a code this cycle |
| out_valid | output | 1 | out_bit is valid |
| out_ready | input | 1 | Sink takes out_bit this cycle |
| out_bit | output | 1 | Serial expanded bit |
| out_last | output | 1 | Final bit of a last-flagged byte |

## Verification
The expansion is exercised with codes at both edges of every range: 1, 2 and 3, 100, and RUN_MAX for the ones-then-zero range; RUN_MAX+1 for the ones-only code; 228, 229 and 254 for the zeros-then-one range; 255; and 0. Together these show whether the block places the range boundaries off by one and whether it gets a run length wrong by one. Codes 228 and 255 both give a single one but come from different ranges, and so do 227 and 226. Comparing each pair tells a missing closing bit apart from an extra one. The last-flag codes, a stalled sink, and a reset in the middle of a run show whether out_last lands on the right bit, whether the output holds under a stall, and whether the preamble restarts.

// File: rtl/rle_pkg.sv
package rle_pkg;

    localparam int CODE_W = 8;
    localparam int CNT_W  = 8;
    localparam int unsigned ZERO_TOP = (2 ** CODE_W) - 2;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // One decoded run: len bits of value val, then an optional closing bit.
    typedef struct packed {
        cnt_t len;
        logic val;
        logic term;
        logic term_val;
    } run_t;

    function automatic run_t plan_run(input code_t b, input int unsigned run_max);
        run_t r;
        int unsigned v;
        r = '0;
        v = int'(b);
        if (v == 0) begin
            r = '0;
        end else if (v <= run_max) begin
            r.len = cnt_t'(v);
            r.val = 1'b1;
            r.term = 1'b1;
            r.term_val = 1'b0;
        end else if (v == run_max + 1) begin
            r.len = cnt_t'(run_max);
            r.val = 1'b1;
            r.term = 1'b0;
        end else if (v <= ZERO_TOP) begin
            r.len = cnt_t'(v - (run_max + 2));
            r.val = 1'b0;
            r.term = 1'b1;
            r.term_val = 1'b1;
        end else begin
            r.len = '0;
            r.term = 1'b1;
            r.term_val = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rle_prefix_gen.sv
module rle_prefix_gen #(
    parameter int PREFIX_W = 16,
    parameter logic [PREFIX_W-1:0] PREFIX_BITS = 16'hFF20
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    output logic active,
    output logic bit_o
);
    localparam int IDX_W = $clog2(PREFIX_W + 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(PREFIX_W);

    logic [IDX_W-1:0] idx_q;

    assign active = (idx_q != IDX_END);
    assign bit_o  = active ? PREFIX_BITS[IDX_END - 1'b1 - idx_q] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (take && active) begin
            idx_q <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/rle_code_decode.sv
module rle_code_decode
    import rle_pkg::*;
#(
    parameter int unsigned RUN_MAX = 226
) (
    input  code_t code,
    output run_t  run
);
    assign run = plan_run(code, RUN_MAX);
endmodule

// File: rtl/rle_run_engine.sv
module rle_run_engine
    import rle_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  run_t run_in,
    input  logic last_in,
    input  logic take,
    output logic busy,
    output logic bit_o,
    output logic final_o
);
    cnt_t cnt_q;
    logic val_q;
    logic term_q;
    logic tval_q;
    logic last_q;
    logic in_run;

    assign in_run  = (cnt_q != '0);
    assign busy    = in_run || term_q;
    assign bit_o   = in_run ? val_q : tval_q;
    assign final_o = last_q && (((cnt_q == cnt_t'(1)) && !term_q) || (!in_run && term_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            val_q  <= 1'b0;
            term_q <= 1'b0;
            tval_q <= 1'b0;
            last_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= run_in.len;
            val_q  <= run_in.val;
            term_q <= run_in.term;
            tval_q <= run_in.term_val;
            last_q <= last_in;
        end else if (take && busy) begin
            if (in_run) begin
                cnt_q <= cnt_q - 1'b1;
            end else begin
                term_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rle_bit_expander.sv
module rle_bit_expander
    import rle_pkg::*;
#(
    parameter int unsigned RUN_MAX = 226,
    parameter int PREFIX_W = 16,
    parameter logic [PREFIX_W-1:0] PREFIX_BITS = 16'hFF20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] in_code,
    input  logic              in_last,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_bit,
    output logic              out_last
);
    logic pre_active;
    logic pre_bit;
    logic eng_busy;
    logic eng_bit;
    logic eng_final;
    logic in_fire;
    run_t dec_run;

    assign in_ready = !pre_active && !eng_busy;
    assign in_fire  = in_valid && in_ready;

    rle_prefix_gen #(
        .PREFIX_W   (PREFIX_W),
        .PREFIX_BITS(PREFIX_BITS)
    ) prefix_i (
        .clk   (clk),
        .rst   (rst),
        .take  (out_ready),
        .active(pre_active),
        .bit_o (pre_bit)
    );

    rle_code_decode #(
        .RUN_MAX(RUN_MAX)
    ) decode_i (
        .code(in_code),
        .run (dec_run)
    );

    rle_run_engine engine_i (
        .clk    (clk),
        .rst    (rst),
        .load   (in_fire),
        .run_in (dec_run),
        .last_in(in_last),
        .take   (out_ready && !pre_active),
        .busy   (eng_busy),
        .bit_o  (eng_bit),
        .final_o(eng_final)
    );

    assign out_valid = pre_active || eng_busy;
    assign out_bit   = pre_active ? pre_bit : eng_bit;
    assign out_last  = !pre_active && eng_final;
endmodule

// File: rtl/rle_expander_chk.sv
module rle_expander_chk #(
    parameter int unsigned RUN_MAX = 226
) (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] in_code,
    input logic       in_last,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic       out_bit,
    input logic       out_last
);
    localparam logic [15:0] PFX = 16'hFF20;

    logic [4:0] sent_q;
    logic       fire;

    assign fire = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            sent_q <= '0;
        end else if (out_valid && out_ready && sent_q < 5'd16) begin
            sent_q <= sent_q + 5'd1;
        end
    end

    a_r1_prefix_gate: assert property (@(posedge clk) disable iff (rst)
        (sent_q < 5'd16) |-> !in_ready);

    a_r1_prefix_value: assert property (@(posedge clk) disable iff (rst)
        (sent_q < 5'd16) |-> (out_valid && out_bit == PFX[4'd15 - sent_q[3:0]] && !out_last));

    a_r2_ones_start: assert property (@(posedge clk) disable iff (rst)
        (fire && in_code >= 8'd1 && 32'(in_code) <= RUN_MAX) |=> (out_valid && out_bit));

    a_r5_single_one: assert property (@(posedge clk) disable iff (rst)
        (fire && in_code == 8'd255) |=> (out_valid && out_bit && out_last == $past(in_last)));

    a_r6_zero_code: assert property (@(posedge clk) disable iff (rst)
        (fire && in_code == 8'd0) |=> (!out_valid && in_ready));

    a_r7_one_in_flight: assert property (@(posedge clk) disable iff (rst)
        (fire && in_code != 8'd0) |=> (out_valid && !in_ready));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last)));

    a_r9_last_valid: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);
endmodule

bind rle_bit_expander rle_expander_chk #(.RUN_MAX(RUN_MAX)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_code  (in_code),
    .in_last  (in_last),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_bit  (out_bit),
    .out_last (out_last)
);

// File: tb/rle_bit_expander_tb_top.sv
module rle_bit_expander_tb_top;
    localparam int RM = 226;
    localparam logic [15:0] PFX = 16'hFF20;
    localparam int NV = 12;
    // bit 8 = in_last, bits 7:0 = code
    localparam logic [8:0] VEC [NV] = '{
        9'h001, 9'h003, 9'h102, 9'h0E2, 9'h0E3, 9'h1E4,
        9'h0E5, 9'h0FE, 9'h1FF, 9'h100, 9'h000, 9'h164
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_code = '0;
    logic in_last = 1'b0;
    logic in_ready;
    logic out_valid;
    logic out_ready = 1'b1;
    logic out_bit;
    logic out_last;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit got_bits [0:299];
    bit got_last [0:299];
    int got_n;
    bit rdy_after;
    bit val_after;

    always #4 clk = ~clk;

    rle_bit_expander dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
        .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid),
        .out_ready(out_ready), .out_bit(out_bit), .out_last(out_last)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(input int b);
        if (b == 0) return 0;
        if (b <= RM) return b + 1;
        if (b == RM + 1) return RM;
        if (b <= 254) return b - (RM + 2) + 1;
        return 1;
    endfunction

    function automatic bit exp_bit(input int b, input int i);
        if (b <= RM) return (i < b);
        if (b == RM + 1) return 1'b1;
        if (b <= 254) return (i == exp_len(b) - 1);
        return 1'b1;
    endfunction

    function automatic string tag(input int b);
        if (b == 0) return "R6";
        if (b <= RM) return "R2";
        if (b == RM + 1) return "R3";
        if (b <= 254) return "R4";
        return "R5";
    endfunction

    task automatic collect();
        got_n = 0;
        while (out_valid && got_n < 300) begin
            got_bits[got_n] = out_bit;
            got_last[got_n] = out_last;
            got_n++;
            @(negedge clk);
        end
    endtask

    task automatic send(input int b, input bit lst);
        @(negedge clk);
        in_valid = 1'b1;
        in_code = 8'(b);
        in_last = lst;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_last = 1'b0;
        rdy_after = in_ready;
        val_after = out_valid;
    endtask

    task automatic verify(input int b, input bit lst);
        int bad_bits = 0;
        int bad_last = 0;
        int len = exp_len(b);
        chk(got_n == len, tag(b), $sformatf("length code %0d", b), got_n, len);
        for (int i = 0; i < got_n && i < len; i++) begin
            if (got_bits[i] != exp_bit(b, i)) bad_bits++;
            if (got_last[i] != (lst && i == len - 1)) bad_last++;
        end
        chk(bad_bits == 0, tag(b), $sformatf("bit mismatches code %0d", b), bad_bits, 0);
        chk(bad_last == 0, "R9", $sformatf("out_last misplaced code %0d", b), bad_last, 0);
        if (b == 0) begin
            chk(rdy_after && !val_after, "R6", "ready/no output after code 0", int'(rdy_after), 1);
        end else begin
            chk(!rdy_after && val_after, "R7", $sformatf("busy after accept code %0d", b), int'(rdy_after), 0);
        end
    endtask

    task automatic check_prefix(input string req);
        int bad = 0;
        int rdy_seen = 0;
        for (int i = 0; i < 16; i++) begin
            if (!out_valid || out_bit != PFX[15 - i] || out_last) bad++;
            if (in_ready) rdy_seen++;
            @(negedge clk);
        end
        chk(bad == 0, req, "preamble bit mismatches", bad, 0);
        chk(rdy_seen == 0, "R1", "in_ready during preamble", rdy_seen, 0);
        chk(in_ready && !out_valid, "R1", "ready after preamble", int'(in_ready), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: state right after reset
        chk(out_valid && out_bit && !in_ready, "R10", "post-reset outputs", int'(out_valid), 1);
        check_prefix("R1");

        // vector table walk
        for (int k = 0; k < NV; k++) begin
            send(int'(VEC[k][7:0]), VEC[k][8]);
            collect();
            verify(int'(VEC[k][7:0]), VEC[k][8]);
        end

        // R8: backpressure holds output
        begin
            int moved = 0;
            out_ready = 1'b0;
            send(5, 1'b1);
            for (int i = 0; i < 3; i++) begin
                if (!out_valid || !out_bit || out_last || in_ready) moved++;
                @(negedge clk);
            end
            chk(moved == 0, "R8", "output held under stall", moved, 0);
            out_ready = 1'b1;
            collect();
            verify(5, 1'b1);
        end

        // R8: stall on the final, last-flagged bit
        begin
            out_ready = 1'b1;
            send(228, 1'b1);
            out_ready = 1'b0;
            @(negedge clk);
            @(negedge clk);
            chk(out_valid && out_bit && out_last, "R8", "final bit held with last", int'(out_last), 1);
            out_ready = 1'b1;
            collect();
            verify(228, 1'b1);
        end

        // R10: reset in the middle of a long run restarts preamble
        begin
            @(negedge clk);
            in_valid = 1'b1;
            in_code = 8'd200;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            repeat (10) @(negedge clk);
            rst = 1'b1;
            @(negedge clk);
            rst = 1'b0;
            chk(out_valid && out_bit && !in_ready, "R10", "restart after mid-run reset", int'(in_ready), 0);
            check_prefix("R10");
            send(1, 1'b0);
            collect();
            verify(1, 1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule